// File: doc/BRIEF.md
# Delta Modulation Sample Channel

This block turns a stream of one-bit delta codes, read byte by byte from system memory, into a 7-bit output level. Software programs four byte-wide registers: a rate/loop register, a direct level register, a start register and a length register. It then turns the channel on through a separate enable write. A bit timer, advanced by a CPU-rate clock enable, sets how often one delta bit is applied. Each bit moves a 6-bit level up or down by one. The level is clamped so that it never leaves the range 1 to 63 by stepping.

Sample bytes come in over a simple read handshake. The channel raises a request with an address and holds it until memory signals ready, and the byte is taken in that same cycle. While a request is waiting, the bit timer stands still. At the end of a sample, the channel either starts again from the cached start and length (loop mode) or goes idle. The output is the 6-bit level shifted up by one, with a software-written bit in the lowest position.

Top module: `dmc_channel`

## Requirements
- R1: After reset, level_out is 0 and mem_valid is low.
- R2: Register 0 bits 3:0 select the bit period, in cpu_ce pulses, from the list (index 0 to 15) 428, 380, 340, 320, 286, 254, 226, 214, 190, 160, 142, 128, 106, 85, 72, 54. Cycles with a fetch outstanding do not count.
- R3: A start fetches its first byte at 0xC000 + 64 × (register 2 value).
- R4: A sample lasts (16 × register 3 value + 1) × 8 bits. One byte is fetched each time the remaining bit count is a nonzero multiple of 8.
- R5: After each completed fetch the address advances by one. From 0xFFFF it goes to 0x8000.
- R6: Bits are applied least significant first, one per bit period. A 1 raises the level if it is below 63. A 0 lowers it if it is above 1.
- R7: Writing register 1 sets the level to bits 6:1 of the data and the output's bit 0 to data bit 0, so level_out equals data bits 6:0 in the next cycle. level_out is always {level, that bit}.
- R8: When the last bit has been applied, the channel reloads the cached start and length and fetches again if register 0 bit 6 is set. Otherwise it goes idle and issues no further requests.
- R9: A control write with ctl_en low stops playback at once: mem_valid drops the next cycle, and the level holds. A control write with ctl_en high starts playback only when the channel is idle, and is ignored while it plays.
- R10: mem_valid, once raised, stays high with a stable mem_addr until mem_ready is seen. During that wait no bit is applied.
- R11: Writes to registers 2 and 3 during playback do not change the running address or length. They take effect at the next start or loop reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_ce | input | 1 | CPU-rate clock enable that advances the bit timer |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register index 0 to 3 |
| wr_data | input | 8 | Register write data |
| ctl_we | input | 1 | Control write strobe |
| ctl_en | input | 1 | Channel enable value carried by a control write |
| mem_valid | output | 1 | Read request pending |
| mem_addr | output | 16 | Read address |
| mem_ready | input | 1 | Memory accepts the request and returns the byte this cycle |
| mem_rdata | input | 8 | Byte returned with mem_ready |
| level_out | output | 7 | Output level |

## Verification
The hardest state to reach from the ports is the address wrap. The wrap happens only after many bytes have been fetched in sequence. For the test, the start register is set to its highest code and the length register to a few blocks, so the fetch walk passes 0xFFFF and continues at 0x8000. Memory-ready stalls are random during this run, and the start and length registers are rewritten part way through. Both clamp limits are reached by preloading the level close to a limit and streaming all-ones or all-zeros bytes. The timer pause is shown by holding ready low while a mid-sample fetch is pending.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

   // register indices decoded by the register block
   localparam logic [1:0] REG_RATE  = 2'd0;
   localparam logic [1:0] REG_LEVEL = 2'd1;
   localparam logic [1:0] REG_START = 2'd2;
   localparam logic [1:0] REG_LEN   = 2'd3;

   // field positions inside the rate register
   localparam int RATE_LO  = 0;
   localparam int LOOP_BIT = 6;

   localparam int PERIOD_BITS = 9;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_FETCH = 2'd1,
      SQ_PLAY  = 2'd2
   } seq_state_e;

   // bit period in clock-enable pulses for each rate code
   function automatic logic [PERIOD_BITS-1:0] rate_period(input logic [3:0] code);
      logic [PERIOD_BITS-1:0] p;
      case (code)
         4'd0:    p = 9'd428;
         4'd1:    p = 9'd380;
         4'd2:    p = 9'd340;
         4'd3:    p = 9'd320;
         4'd4:    p = 9'd286;
         4'd5:    p = 9'd254;
         4'd6:    p = 9'd226;
         4'd7:    p = 9'd214;
         4'd8:    p = 9'd190;
         4'd9:    p = 9'd160;
         4'd10:   p = 9'd142;
         4'd11:   p = 9'd128;
         4'd12:   p = 9'd106;
         4'd13:   p = 9'd85;
         4'd14:   p = 9'd72;
         default: p = 9'd54;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/dmc_regs.sv
module dmc_regs
   import dmc_pkg::*;
#(
   parameter int                ADDR_W      = 16,
   parameter int                LEN_W       = 15,
   parameter int                LEVEL_W     = 6,
   parameter int                PER_W       = 9,
   parameter logic [ADDR_W-1:0] BASE_ADDR   = 16'hC000,
   parameter int                START_SHIFT = 6,
   parameter int                LEN_GRAN    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [7:0]        wr_data,
   output logic [PER_W-1:0]  period,
   output logic              loop_en,
   output logic [ADDR_W-1:0] cache_addr,
   output logic [LEN_W-1:0]  cache_len,
   output logic              lvl_load,
   output logic [LEVEL_W-1:0] lvl_val,
   output logic              out_lsb
);

   localparam int BYTE_BITS_LOG = 3;

   logic [3:0] rate_q;
   logic       loop_q;
   logic [7:0] start_q;
   logic [7:0] len_q;
   logic       lsb_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rate_q  <= '0;
         loop_q  <= 1'b0;
         start_q <= '0;
         len_q   <= '0;
         lsb_q   <= 1'b0;
      end else if (wr_en) begin
         case (wr_sel)
            REG_RATE: begin
               rate_q <= wr_data[RATE_LO +: 4];
               loop_q <= wr_data[LOOP_BIT];
            end
            REG_LEVEL: lsb_q   <= wr_data[0];
            REG_START: start_q <= wr_data;
            default:   len_q   <= wr_data;
         endcase
      end
   end

   assign period     = PER_W'(rate_period(rate_q));
   assign loop_en    = loop_q;
   assign cache_addr = BASE_ADDR + (ADDR_W'(start_q) << START_SHIFT);
   assign cache_len  = ((LEN_W'(len_q) << LEN_GRAN) + LEN_W'(1)) << BYTE_BITS_LOG;
   assign lvl_load   = wr_en && (wr_sel == REG_LEVEL);
   assign lvl_val    = wr_data[LEVEL_W:1];
   assign out_lsb    = lsb_q;

endmodule

// File: rtl/dmc_timer.sv
module dmc_timer #(
   parameter int PER_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             ce,
   input  logic             restart,
   input  logic [PER_W-1:0] period,
   output logic             tick
);

   logic [PER_W-1:0] cnt_q;

   // ">=" keeps the timer bounded if the period shrinks mid-count
   assign tick = run && ce && (cnt_q >= (period - PER_W'(1)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (run && ce) begin
         cnt_q <= tick ? '0 : cnt_q + PER_W'(1);
      end
   end

endmodule

// File: rtl/dmc_seq.sv
module dmc_seq
   import dmc_pkg::*;
#(
   parameter int                ADDR_W    = 16,
   parameter int                LEN_W     = 15,
   parameter logic [ADDR_W-1:0] WRAP_ADDR = 16'h8000,
   parameter bit                LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              kill,
   input  logic              start_req,
   input  logic [ADDR_W-1:0] cache_addr,
   input  logic [LEN_W-1:0]  cache_len,
   input  logic              loop_en,
   input  logic              tick,
   input  logic              mem_ready,
   input  logic [7:0]        mem_rdata,
   output logic              mem_valid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              run,
   output logic              restart,
   output logic              bit_stb,
   output logic              bit_val
);

   seq_state_e        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  remain_q;
   logic [7:0]        shreg_q;
   logic [7:0]        shreg_nxt;
   logic [ADDR_W-1:0] addr_inc;
   logic [LEN_W-1:0]  remain_dec;
   logic              go;

   generate
      if (LSB_FIRST) begin : g_lsb_first
         assign bit_val   = shreg_q[0];
         assign shreg_nxt = {1'b0, shreg_q[7:1]};
      end else begin : g_msb_first
         assign bit_val   = shreg_q[7];
         assign shreg_nxt = {shreg_q[6:0], 1'b0};
      end
   endgenerate

   assign addr_inc   = (addr_q == '1) ? WRAP_ADDR : addr_q + ADDR_W'(1);
   assign remain_dec = remain_q - LEN_W'(1);
   assign go         = start_req && (state_q == SQ_IDLE) && !kill;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= SQ_IDLE;
         addr_q   <= '0;
         remain_q <= '0;
         shreg_q  <= '0;
      end else if (kill) begin
         state_q  <= SQ_IDLE;
         remain_q <= '0;
      end else if (go) begin
         state_q  <= SQ_FETCH;
         addr_q   <= cache_addr;
         remain_q <= cache_len;
      end else begin
         case (state_q)
            SQ_FETCH: begin
               if (mem_ready) begin
                  shreg_q <= mem_rdata;
                  addr_q  <= addr_inc;
                  state_q <= SQ_PLAY;
               end
            end
            SQ_PLAY: begin
               if (tick) begin
                  shreg_q  <= shreg_nxt;
                  remain_q <= remain_dec;
                  if (remain_dec == '0) begin
                     if (loop_en) begin
                        addr_q   <= cache_addr;
                        remain_q <= cache_len;
                        state_q  <= SQ_FETCH;
                     end else begin
                        state_q  <= SQ_IDLE;
                     end
                  end else if (remain_dec[2:0] == 3'd0) begin
                     state_q <= SQ_FETCH;
                  end
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign mem_valid = (state_q == SQ_FETCH);
   assign mem_addr  = addr_q;
   assign run       = (state_q == SQ_PLAY);
   assign restart   = go;
   assign bit_stb   = tick && !kill;

endmodule

// File: rtl/dmc_level.sv
module dmc_level #(
   parameter int LEVEL_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [LEVEL_W-1:0] load_val,
   input  logic               step,
   input  logic               up,
   output logic [LEVEL_W-1:0] level
);

   localparam logic [LEVEL_W-1:0] LVL_MAX = '1;
   localparam logic [LEVEL_W-1:0] LVL_MIN = LEVEL_W'(1);

   logic [LEVEL_W-1:0] lvl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q <= '0;
      end else if (load) begin
         lvl_q <= load_val;
      end else if (step) begin
         if (up && (lvl_q < LVL_MAX)) begin
            lvl_q <= lvl_q + LEVEL_W'(1);
         end else if (!up && (lvl_q > LVL_MIN)) begin
            lvl_q <= lvl_q - LEVEL_W'(1);
         end
      end
   end

   assign level = lvl_q;

endmodule

// File: rtl/dmc_channel.sv
module dmc_channel #(
   parameter int                ADDR_W      = 16,
   parameter int                LEVEL_W     = 6,
   parameter int                PER_W       = 9,
   parameter logic [ADDR_W-1:0] BASE_ADDR   = 16'hC000,
   parameter logic [ADDR_W-1:0] WRAP_ADDR   = 16'h8000,
   parameter int                START_SHIFT = 6,
   parameter int                LEN_GRAN    = 4,
   parameter bit                LSB_FIRST   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_ce,
   input  logic               wr_en,
   input  logic [1:0]         wr_sel,
   input  logic [7:0]         wr_data,
   input  logic               ctl_we,
   input  logic               ctl_en,
   output logic               mem_valid,
   output logic [ADDR_W-1:0]  mem_addr,
   input  logic               mem_ready,
   input  logic [7:0]         mem_rdata,
   output logic [LEVEL_W:0]   level_out
);

   localparam int LEN_W = 8 + LEN_GRAN + 3;

   generate
      if (LEVEL_W < 2 || LEVEL_W > 7) begin : g_bad_level
         $error("dmc_channel: LEVEL_W must lie in 2..7");
      end
      if (PER_W < dmc_pkg::PERIOD_BITS) begin : g_bad_per
         $error("dmc_channel: PER_W too narrow for the period list");
      end
      if (ADDR_W < 8 + START_SHIFT) begin : g_bad_addr
         $error("dmc_channel: ADDR_W too narrow for the start field");
      end
   endgenerate

   logic [PER_W-1:0]   period;
   logic               loop_en;
   logic [ADDR_W-1:0]  cache_addr;
   logic [LEN_W-1:0]   cache_len;
   logic               lvl_load;
   logic [LEVEL_W-1:0] lvl_val;
   logic               out_lsb;
   logic               run;
   logic               restart;
   logic               tick;
   logic               bit_stb;
   logic               bit_val;
   logic               kill;
   logic               start_req;
   logic [LEVEL_W-1:0] level;

   assign kill      = ctl_we && !ctl_en;
   assign start_req = ctl_we && ctl_en;

   dmc_regs #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LEVEL_W(LEVEL_W), .PER_W(PER_W),
      .BASE_ADDR(BASE_ADDR), .START_SHIFT(START_SHIFT), .LEN_GRAN(LEN_GRAN)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .period(period), .loop_en(loop_en), .cache_addr(cache_addr),
      .cache_len(cache_len), .lvl_load(lvl_load), .lvl_val(lvl_val),
      .out_lsb(out_lsb)
   );

   dmc_timer #(.PER_W(PER_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(run), .ce(cpu_ce), .restart(restart),
      .period(period), .tick(tick)
   );

   dmc_seq #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .WRAP_ADDR(WRAP_ADDR), .LSB_FIRST(LSB_FIRST)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .kill(kill), .start_req(start_req),
      .cache_addr(cache_addr), .cache_len(cache_len), .loop_en(loop_en),
      .tick(tick), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
      .mem_valid(mem_valid), .mem_addr(mem_addr), .run(run),
      .restart(restart), .bit_stb(bit_stb), .bit_val(bit_val)
   );

   dmc_level #(.LEVEL_W(LEVEL_W)) u_level (
      .clk(clk), .rst_n(rst_n), .load(lvl_load), .load_val(lvl_val),
      .step(bit_stb), .up(bit_val), .level(level)
   );

   assign level_out = {level, out_lsb};

endmodule

// File: rtl/dmc_channel_chk.sv
module dmc_channel_chk #(
   parameter int                ADDR_W    = 16,
   parameter int                LEVEL_W   = 6,
   parameter logic [ADDR_W-1:0] WRAP_ADDR = 16'h8000
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [1:0]         wr_sel,
   input logic [LEVEL_W:0]   wr_low,
   input logic               ctl_we,
   input logic               ctl_en,
   input logic               mem_valid,
   input logic [ADDR_W-1:0]  mem_addr,
   input logic               mem_ready,
   input logic [LEVEL_W:0]   level_out
);

   logic             load_now;
   logic [LEVEL_W:0] lvl_ext;

   assign load_now = wr_en && (wr_sel == 2'd1);
   assign lvl_ext  = {1'b0, level_out[LEVEL_W:1]};

   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready && !(ctl_we && !ctl_en) |=> mem_valid && $stable(mem_addr));

   p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we && !ctl_en |=> !mem_valid);

   p_addr_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> mem_addr >= WRAP_ADDR);

   p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      load_now |=> level_out == $past(wr_low));

   p_lsb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !load_now |=> level_out[0] == $past(level_out[0]));

   p_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !load_now |=> (lvl_ext == $past(lvl_ext)) ||
                    (lvl_ext == $past(lvl_ext) + 1'b1) ||
                    (lvl_ext + 1'b1 == $past(lvl_ext)));

   p_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !load_now && (level_out[LEVEL_W:1] != '0) |=> level_out[LEVEL_W:1] != '0);

endmodule

bind dmc_channel dmc_channel_chk #(
   .ADDR_W(ADDR_W), .LEVEL_W(LEVEL_W), .WRAP_ADDR(WRAP_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
   .wr_low(wr_data[LEVEL_W:0]), .ctl_we(ctl_we), .ctl_en(ctl_en),
   .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_ready(mem_ready),
   .level_out(level_out)
);

// File: tb/sim_dmc_channel.sv
`timescale 1ns/1ps
module sim_dmc_channel;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_ce = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [7:0]  wr_data = 8'd0;
   logic        ctl_we = 1'b0;
   logic        ctl_en = 1'b0;
   logic        mem_ready = 1'b0;
   logic        mem_valid;
   logic [15:0] mem_addr;
   logic [7:0]  mem_rdata;
   logic [6:0]  level_out;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int mem_mode = 0;      // 0 hashed bytes, 1 all ones, 2 all zeros
   int ce_mode = 0;       // 0 every cycle, 1 every other cycle
   int rdy_mode = 0;      // 0 always ready, 1 pseudo-random
   bit rdy_hold = 1'b0;
   bit cmp_on = 1'b0;
   logic [15:0] lfsr = 16'hACE1;
   int ce_ph = 0;
   int fq[$];

   int rate_tbl[16] = '{428, 380, 340, 320, 286, 254, 226, 214,
                        190, 160, 142, 128, 106, 85, 72, 54};

   always #10 clk = ~clk;

   dmc_channel u0 (
      .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .ctl_we(ctl_we), .ctl_en(ctl_en),
      .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_ready(mem_ready),
      .mem_rdata(mem_rdata), .level_out(level_out)
   );

   function automatic int mem_fn(int a);
      if (mem_mode == 1) return 255;
      if (mem_mode == 2) return 0;
      return ((a * 37) ^ (a >> 8) ^ 8'h5A) & 255;
   endfunction

   assign mem_rdata = 8'(mem_fn(int'(mem_addr)));

   task automatic check(string tag, int act, int exp, string what);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // input drivers for enable and ready, a little after each rising edge
   always @(posedge clk) begin
      #2;
      ce_ph++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cpu_ce = (ce_mode == 0) ? 1'b1 : ((ce_ph % 2) == 0);
      mem_ready = rdy_hold ? 1'b0 : ((rdy_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[5]));
   end

   // behavioural reference model
   int m_state, m_addr, m_rem, m_cnt, m_lv, m_lsb, m_sel, m_loop, m_r2, m_r3, m_byte;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_addr = 0; m_rem = 0; m_cnt = 0; m_lv = 0; m_lsb = 0;
         m_sel = 0; m_loop = 0; m_r2 = 0; m_r3 = 0; m_byte = 0;
      end else begin
         int per;
         bit do_bit;
         int bitv;
         per = rate_tbl[m_sel];
         do_bit = 1'b0;
         bitv = 0;
         if (ctl_we && !ctl_en) begin
            m_state = 0; m_rem = 0;
         end else if (ctl_we && ctl_en && m_state == 0) begin
            m_state = 1; m_addr = 49152 + m_r2 * 64; m_rem = (m_r3 * 16 + 1) * 8; m_cnt = 0;
         end else if (m_state == 1) begin
            if (mem_ready) begin
               m_byte = mem_fn(m_addr);
               m_addr = (m_addr == 65535) ? 32768 : m_addr + 1;
               m_state = 2;
            end
         end else if (m_state == 2 && cpu_ce) begin
            if (m_cnt >= per - 1) begin
               m_cnt = 0; do_bit = 1'b1; bitv = m_byte & 1; m_byte = m_byte >> 1;
               m_rem--;
               if (m_rem == 0) begin
                  if (m_loop != 0) begin
                     m_addr = 49152 + m_r2 * 64; m_rem = (m_r3 * 16 + 1) * 8; m_state = 1;
                  end else m_state = 0;
               end else if (m_rem % 8 == 0) m_state = 1;
            end else m_cnt++;
         end
         if (wr_en && wr_sel == 2'd1) begin
            m_lv = (wr_data >> 1) & 63; m_lsb = wr_data & 1;
         end else if (do_bit) begin
            if (bitv != 0 && m_lv < 63) m_lv++;
            else if (bitv == 0 && m_lv > 1) m_lv--;
         end
         if (wr_en) begin
            case (wr_sel)
               2'd0: begin m_sel = wr_data & 15; m_loop = (wr_data >> 6) & 1; end
               2'd2: m_r2 = wr_data;
               2'd3: m_r3 = wr_data;
               default: ;
            endcase
         end
      end
   end

   // per-cycle comparison and fetch log at the falling edge
   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         check("R6", int'(level_out), m_lv * 2 + m_lsb, "level vs model");
         check("R10", int'(mem_valid), int'(m_state == 1), "request vs model");
         if (m_state == 1) check("R5", int'(mem_addr), m_addr, "address vs model");
      end
      if (rst_n && mem_valid && mem_ready) fq.push_back(int'(mem_addr));
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         bad++; total++;
         $display("FAIL watchdog (all requirements): actual=%0d expected<=190000 cycles", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic wr_reg(int sel, int val);
      @(posedge clk); #3;
      wr_en = 1'b1; wr_sel = 2'(sel); wr_data = 8'(val);
      @(posedge clk); #3;
      wr_en = 1'b0;
   endtask

   task automatic ctl(bit en);
      @(posedge clk); #3;
      ctl_we = 1'b1; ctl_en = en;
      @(posedge clk); #3;
      ctl_we = 1'b0;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (m_state != 0);
   endtask

   task automatic wait_fetches(int n);
      do @(negedge clk); while (fq.size() < n);
   endtask

   task automatic step_interval(output int cnt);
      int prev;
      prev = int'(level_out);
      do @(negedge clk); while (int'(level_out) == prev);
      prev = int'(level_out);
      cnt = 0;
      do begin @(negedge clk); cnt++; end while (int'(level_out) == prev);
   endtask

   initial begin
      int gap;
      int lv;
      int n;
      int cap;
      repeat (4) @(negedge clk);
      check("R1", int'(level_out), 0, "level in reset");
      check("R1", int'(mem_valid), 0, "request in reset");
      @(posedge clk); #3; rst_n = 1'b1;
      @(negedge clk);
      check("R1", int'(level_out), 0, "level after reset");
      check("R1", int'(mem_valid), 0, "request after reset");
      cmp_on = 1'b1;

      // single byte at fastest rate
      wr_reg(1, 'h15);
      @(negedge clk);
      check("R7", int'(level_out), 'h15, "direct level load");
      wr_reg(0, 'h0F); wr_reg(2, 'h10); wr_reg(3, 0);
      mem_mode = 1; fq.delete();
      ctl(1'b1);
      wait_fetches(1);
      check("R3", fq[0], 'hC400, "start address");
      step_interval(gap);
      check("R2", gap, 54, "period code 15");
      wait_idle();
      repeat (5) @(negedge clk);
      check("R4", fq.size(), 1, "fetches for length code 0");
      check("R6", int'(level_out), 37, "eight ones from level 10");
      repeat (200) @(negedge clk);
      check("R8", fq.size(), 1, "no fetch after end without loop");
      check("R8", int'(mem_valid), 0, "idle after end");

      // slowest rate, half-rate enable, upper clamp
      ce_mode = 1;
      wr_reg(1, 'h78); wr_reg(0, 'h00);
      fq.delete();
      ctl(1'b1);
      step_interval(gap);
      check("R2", gap, 856, "period code 0 at half-rate enable");
      wait_idle();
      check("R6", int'(level_out), 126, "upper clamp at 63");

      // lower clamp
      ce_mode = 0; mem_mode = 2;
      wr_reg(1, 'h0A); wr_reg(0, 'h0F);
      ctl(1'b1);
      wait_idle();
      check("R6", int'(level_out), 2, "lower clamp at 1");

      // address wrap with random stalls and mid-run register rewrites
      rdy_mode = 1; mem_mode = 0;
      wr_reg(2, 'hFF); wr_reg(3, 4);
      fq.delete();
      ctl(1'b1);
      wait_fetches(3);
      wr_reg(2, 0); wr_reg(3, 0);
      wait_idle();
      check("R4", fq.size(), 65, "fetches for length code 4");
      check("R3", fq[0], 'hFFC0, "start address code FF");
      check("R11", fq[10], 'hFFCA, "address unaffected by rewrite");
      check("R5", fq[63], 'hFFFF, "top address");
      check("R5", fq[64], 'h8000, "wrap address");

      // looping
      rdy_mode = 0;
      wr_reg(0, 'h4F); wr_reg(2, 2); wr_reg(3, 0);
      fq.delete();
      ctl(1'b1);
      wait_fetches(3);
      for (int i = 0; i < 3; i++) check("R8", fq[i], 'hC080, "loop reload address");
      ctl(1'b0);
      @(negedge clk);
      check("R9", int'(mem_valid), 0, "request dropped on stop");
      lv = int'(level_out); n = fq.size();
      repeat (300) @(negedge clk);
      check("R9", int'(level_out), lv, "level held after stop");
      check("R9", fq.size(), n, "no fetch after stop");

      // enable while playing is ignored
      wr_reg(0, 'h0F); wr_reg(2, 4); wr_reg(3, 1);
      fq.delete();
      ctl(1'b1);
      wait_fetches(2);
      ctl(1'b1);
      wait_fetches(3);
      check("R9", fq[2], 'hC102, "no restart while playing");

      // stall a mid-sample fetch
      rdy_hold = 1'b1;
      do @(negedge clk); while (!mem_valid);
      cap = int'(mem_addr); lv = int'(level_out);
      repeat (100) @(negedge clk);
      check("R10", int'(mem_valid), 1, "request held while not ready");
      check("R10", int'(mem_addr), cap, "address stable while not ready");
      check("R10", int'(level_out), lv, "no bit applied during wait");
      rdy_hold = 1'b0;
      n = fq.size();
      wait_fetches(n + 1);
      check("R10", fq[n], cap, "held address accepted");
      ctl(1'b0);
      repeat (10) @(negedge clk);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule